// File: doc/BRIEF.md
# QCIF Capture Window Controller

This block sits between the parallel pixel output of a video decoder and a frame-buffer FIFO. It runs in the decoder's sampling clock domain. A companion half-rate pulse, `half_en_i`, is used as a clock enable and marks the cycles that carry a pixel. The block watches the line-valid, line-sync, field-sync and field-parity inputs and tracks where the current sample sits in the field. From that position it keeps a regular grid of samples that forms a 176 x 144 image.

For every kept sample it issues one write toward the FIFO: a chip select, a write strobe, a raster-order address and the pixel value. Capture is armed only at the start of a field of the selected parity, and only if the capture enable is high at that moment. A frame therefore always begins at a field boundary. When the last pixel of the window is written, a one-cycle completion pulse follows. If a new field begins before the window is full, the unfinished frame is abandoned and a flag is raised.

Horizontal and vertical decimation ratios, the output size, the pixel width and the captured parity are all parameters. With the defaults, 704 active samples per line and 288 lines per field reduce to 176 x 144.

Top module: `qcif_capture_win`

## Requirements
- R1: While `rst_ni` is low, `fifo_cs_o`, `fifo_we_o`, `fifo_addr_o`, `fifo_data_o`, `frame_done_o` and `short_frame_o` are all 0.
- R2: The inputs are sampled only on rising clock edges where `half_en_i` is 1. A change that is seen only at edges with `half_en_i` low has no effect, and no write strobe appears in the clock that follows such an edge.
- R3: Active samples of a line are numbered from 0. The numbering restarts after line-valid falls and after a line-sync rising edge. In a kept line, sample k is written exactly when k mod H_DEC = 0 and k / H_DEC < OUT_W.
- R4: Active lines of a field are numbered from 0 at the field-sync rising edge. A line counts as finished when line-valid falls. Line j is kept exactly when j mod V_DEC = 0 and j / V_DEC < OUT_H.
- R5: Capture is armed only at a field-sync rising edge where `field_odd_i` equals CAP_ODD (1 = odd field, the default). A field of the other parity produces no writes.
- R6: `capture_en_i` is sampled only at a field-sync rising edge. A change in the middle of a field neither starts nor stops the current capture.
- R7: Each write appears one clock after the sampling edge as `fifo_we_o` = `fifo_cs_o` = 1 for exactly one clock. In that clock `fifo_data_o` holds the sampled pixel and `fifo_addr_o` holds the write address.
- R8: The first write of a frame uses address 0, and each later write uses the previous address plus 1. The last write uses OUT_W*OUT_H-1. After that, no write occurs until capture is armed again.
- R9: `frame_done_o` is 1 for exactly one clock: the clock right after the strobe of the write to address OUT_W*OUT_H-1.
- R10: A field-sync rising edge while a frame is still incomplete stops that frame and sets `short_frame_o` from the next clock on. The flag clears in the same clock as the strobe of the last write of a later complete frame.
- R11: A line-sync rising edge in the middle of an active line restarts the sample numbering at that sample. If line-valid is high, that sample is number 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Decoder sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_en_i | input | 1 | Half-rate pixel enable |
| line_valid_i | input | 1 | High during the active samples of a line |
| line_sync_i | input | 1 | Line sync; its rising edge restarts the sample numbering |
| field_sync_i | input | 1 | Field sync; its rising edge starts a field |
| field_odd_i | input | 1 | Field parity, 1 = odd |
| capture_en_i | input | 1 | Capture request, sampled at the field start |
| pix_data_i | input | DATA_W | Pixel sample |
| fifo_cs_o | output | 1 | FIFO chip select |
| fifo_we_o | output | 1 | FIFO write strobe |
| fifo_addr_o | output | ADDR_W | Frame-memory write address |
| fifo_data_o | output | DATA_W | Pixel written to the FIFO |
| frame_done_o | output | 1 | One-clock pulse after the last pixel of a frame |
| short_frame_o | output | 1 | Set when a frame was cut short by a new field |

## Verification
Some properties are checked on every clock. Write addresses stay contiguous and in range, and the completion pulse only ever follows the final-address write. No strobe follows an edge without the pixel enable, the short-frame flag rises only after a field start, and the position counters stay within their bounds. The scenarios cover the behaviour that spans whole fields, which only a reference model can show: which samples and lines are kept, parity selection, when the enable takes effect, recovery after a truncated field, and a line sync arriving mid-line.

// File: rtl/vcw_pkg.sv
package vcw_pkg;
  typedef struct packed {
    logic lv;       // line valid, current sample
    logic lv_fall;  // end of an active line
    logic ls_rise;  // line sync leading edge
    logic fs_rise;  // field sync leading edge
  } sync_ev_t;
endpackage

// File: rtl/vcw_sync_edges.sv
module vcw_sync_edges
  import vcw_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     line_valid_i,
  input  logic     line_sync_i,
  input  logic     field_sync_i,
  output sync_ev_t ev_o
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] cur;
  logic [NSIG-1:0] prev_q;

  assign cur = {field_sync_i, line_sync_i, line_valid_i};

  // previous value is only advanced on pixel-enable edges
  for (genvar g = 0; g < NSIG; g++) begin : g_prev
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   prev_q[g] <= 1'b0;
      else if (en_i) prev_q[g] <= cur[g];
    end
  end

  always_comb begin
    ev_o.lv      = cur[0];
    ev_o.lv_fall = ~cur[0] & prev_q[0];
    ev_o.ls_rise = cur[1] & ~prev_q[1];
    ev_o.fs_rise = cur[2] & ~prev_q[2];
  end
endmodule

// File: rtl/vcw_raster.sv
module vcw_raster
  import vcw_pkg::*;
#(
  parameter int H_DEC = 4,
  parameter int V_DEC = 2,
  parameter int OUT_W = 176,
  parameter int OUT_H = 144
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  sync_ev_t ev_i,
  output logic     keep_o
);
  localparam int HPW = (H_DEC > 1) ? $clog2(H_DEC) : 1;
  localparam int VPW = (V_DEC > 1) ? $clog2(V_DEC) : 1;
  localparam int CW  = $clog2(OUT_W + 1);
  localparam int RW  = $clog2(OUT_H + 1);

  logic [HPW-1:0] h_ph_q, h_ph_eff;
  logic [CW-1:0]  col_q, col_eff;
  logic [VPW-1:0] v_ph_q;
  logic [RW-1:0]  row_q;
  logic           h_wrap, v_wrap;

  // line sync in this sample restarts numbering at this sample
  assign h_ph_eff = ev_i.ls_rise ? '0 : h_ph_q;
  assign col_eff  = ev_i.ls_rise ? '0 : col_q;
  assign h_wrap   = (h_ph_eff == HPW'(H_DEC - 1));
  assign v_wrap   = (v_ph_q == VPW'(V_DEC - 1));

  assign keep_o = ev_i.lv && !ev_i.fs_rise && (h_ph_eff == '0) &&
                  (col_eff < CW'(OUT_W)) && (v_ph_q == '0) && (row_q < RW'(OUT_H));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_ph_q <= '0;
      col_q  <= '0;
      v_ph_q <= '0;
      row_q  <= '0;
    end else if (en_i) begin
      if (ev_i.fs_rise) begin
        h_ph_q <= '0;
        col_q  <= '0;
        v_ph_q <= '0;
        row_q  <= '0;
      end else if (ev_i.lv) begin
        h_ph_q <= h_wrap ? '0 : h_ph_eff + 1'b1;
        col_q  <= (h_wrap && col_eff < CW'(OUT_W)) ? col_eff + 1'b1 : col_eff;
      end else if (ev_i.lv_fall) begin
        h_ph_q <= '0;
        col_q  <= '0;
        v_ph_q <= v_wrap ? '0 : v_ph_q + 1'b1;
        if (v_wrap && row_q < RW'(OUT_H)) row_q <= row_q + 1'b1;
      end else if (ev_i.ls_rise) begin
        h_ph_q <= '0;
        col_q  <= '0;
      end
    end
  end

  assert_col_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q <= CW'(OUT_W));
  assert_row_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_q <= RW'(OUT_H));
  assert_field_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ev_i.fs_rise) |=> (row_q == '0 && v_ph_q == '0));
endmodule

// File: rtl/vcw_frame_ctrl.sv
module vcw_frame_ctrl #(
  parameter int DATA_W  = 8,
  parameter int OUT_W   = 176,
  parameter int OUT_H   = 144,
  parameter bit CAP_ODD = 1'b1,
  localparam int TOTAL  = OUT_W * OUT_H,
  localparam int ADDR_W = $clog2(TOTAL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              half_en_i,
  input  logic              fs_rise_i,
  input  logic              keep_i,
  input  logic              field_odd_i,
  input  logic              capture_en_i,
  input  logic [DATA_W-1:0] pix_data_i,
  output logic              fifo_cs_o,
  output logic              fifo_we_o,
  output logic [ADDR_W-1:0] fifo_addr_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              frame_done_o,
  output logic              short_frame_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(TOTAL - 1);

  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q        <= 1'b0;
      addr_q        <= '0;
      fifo_cs_o     <= 1'b0;
      fifo_we_o     <= 1'b0;
      fifo_addr_o   <= '0;
      fifo_data_o   <= '0;
      short_frame_o <= 1'b0;
      frame_done_o  <= 1'b0;
    end else begin
      fifo_cs_o    <= 1'b0;
      fifo_we_o    <= 1'b0;
      frame_done_o <= fifo_we_o && (fifo_addr_o == LAST);
      if (half_en_i) begin
        if (fs_rise_i) begin
          if (busy_q) short_frame_o <= 1'b1;   // window cut short
          busy_q <= capture_en_i && (field_odd_i == CAP_ODD);
          addr_q <= '0;
        end else if (busy_q && keep_i) begin
          fifo_cs_o   <= 1'b1;
          fifo_we_o   <= 1'b1;
          fifo_addr_o <= addr_q;
          fifo_data_o <= pix_data_i;
          if (addr_q == LAST) begin
            busy_q        <= 1'b0;
            short_frame_o <= 1'b0;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
      end
    end
  end

  // last address written, for the contiguity check
  logic [ADDR_W-1:0] last_wr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        last_wr_q <= '0;
    else if (fifo_we_o) last_wr_q <= fifo_addr_o;
  end

  assert_addr_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_we_o && fifo_addr_o != '0) |-> fifo_addr_o == ADDR_W'(last_wr_q + 1'b1));
  assert_addr_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |-> fifo_addr_o <= LAST);
  assert_done_after_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> ($past(fifo_we_o) && $past(fifo_addr_o) == LAST));
  assert_gated_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(half_en_i) |-> !fifo_we_o);
  assert_cs_with_we_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |=> !fifo_we_o || $past(half_en_i));
  assert_short_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(short_frame_o) |-> $past(fs_rise_i && half_en_i));
endmodule

// File: rtl/qcif_capture_win.sv
module qcif_capture_win
  import vcw_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int H_DEC   = 4,
  parameter int V_DEC   = 2,
  parameter int OUT_W   = 176,
  parameter int OUT_H   = 144,
  parameter bit CAP_ODD = 1'b1,
  localparam int ADDR_W = $clog2(OUT_W * OUT_H)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              half_en_i,
  input  logic              line_valid_i,
  input  logic              line_sync_i,
  input  logic              field_sync_i,
  input  logic              field_odd_i,
  input  logic              capture_en_i,
  input  logic [DATA_W-1:0] pix_data_i,
  output logic              fifo_cs_o,
  output logic              fifo_we_o,
  output logic [ADDR_W-1:0] fifo_addr_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              frame_done_o,
  output logic              short_frame_o
);
  sync_ev_t ev;
  logic     keep;

  vcw_sync_edges i_edges (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (half_en_i),
    .line_valid_i (line_valid_i),
    .line_sync_i  (line_sync_i),
    .field_sync_i (field_sync_i),
    .ev_o         (ev)
  );

  vcw_raster #(
    .H_DEC (H_DEC),
    .V_DEC (V_DEC),
    .OUT_W (OUT_W),
    .OUT_H (OUT_H)
  ) i_raster (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (half_en_i),
    .ev_i   (ev),
    .keep_o (keep)
  );

  vcw_frame_ctrl #(
    .DATA_W  (DATA_W),
    .OUT_W   (OUT_W),
    .OUT_H   (OUT_H),
    .CAP_ODD (CAP_ODD)
  ) i_frame (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .half_en_i     (half_en_i),
    .fs_rise_i     (ev.fs_rise),
    .keep_i        (keep),
    .field_odd_i   (field_odd_i),
    .capture_en_i  (capture_en_i),
    .pix_data_i    (pix_data_i),
    .fifo_cs_o     (fifo_cs_o),
    .fifo_we_o     (fifo_we_o),
    .fifo_addr_o   (fifo_addr_o),
    .fifo_data_o   (fifo_data_o),
    .frame_done_o  (frame_done_o),
    .short_frame_o (short_frame_o)
  );
endmodule

// File: tb/test_qcif_capture_win.sv
`timescale 1ns/1ps
module test_qcif_capture_win;
  localparam int DW = 8, HD = 4, VD = 2, OW = 8, OH = 6;
  localparam int TOT = OW * OH;
  localparam int AW = $clog2(TOT);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic half_en_i = 1'b0, line_valid_i = 1'b0, line_sync_i = 1'b0, field_sync_i = 1'b0;
  logic field_odd_i = 1'b0, capture_en_i = 1'b0;
  logic [DW-1:0] pix_data_i = '0;
  logic fifo_cs_o, fifo_we_o, frame_done_o, short_frame_o;
  logic [AW-1:0] fifo_addr_o;
  logic [DW-1:0] fifo_data_o;

  always #2 clk_i = ~clk_i;

  qcif_capture_win #(.DATA_W(DW), .H_DEC(HD), .V_DEC(VD), .OUT_W(OW), .OUT_H(OH),
                     .CAP_ODD(1'b1)) i_qcif_capture_win (.*);

  int checks = 0, fails = 0, wr_cnt = 0, done_cnt = 0;
  bit finished = 0;

  // reference model state
  int  m_pix = 0, m_line = 0, m_waddr = 0;
  bit  m_busy = 0, m_fs_p = 0, m_ls_p = 0, m_lv_p = 0;
  bit  e_we = 0, e_done = 0, e_short = 0;
  int  e_addr = 0, e_data = 0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_pix = 0; m_line = 0; m_waddr = 0; m_busy = 0;
      m_fs_p = 0; m_ls_p = 0; m_lv_p = 0;
      e_we = 0; e_done = 0; e_short = 0; e_addr = 0; e_data = 0;
    end else begin
      e_done = e_we && (e_addr == TOT - 1);
      e_we = 0;
      if (half_en_i) begin
        if (field_sync_i && !m_fs_p) begin
          if (m_busy) e_short = 1;
          m_busy = capture_en_i && field_odd_i;
          m_waddr = 0; m_pix = 0; m_line = 0;
        end else begin
          if (line_sync_i && !m_ls_p) m_pix = 0;
          if (line_valid_i) begin
            if (m_busy && m_pix % HD == 0 && m_pix / HD < OW &&
                m_line % VD == 0 && m_line / VD < OH) begin
              e_we = 1; e_addr = m_waddr; e_data = int'(pix_data_i);
              m_waddr++;
              if (m_waddr == TOT) begin m_busy = 0; e_short = 0; end
            end
            m_pix++;
          end else if (m_lv_p) begin
            m_pix = 0; m_line++;
          end
        end
        m_fs_p = field_sync_i; m_ls_p = line_sync_i; m_lv_p = line_valid_i;
      end
    end
  end

  task automatic fail_line(string req, string what, int act, int exp);
    fails++;
    $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
  endtask

  // every-clock comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      checks++;
      if (fifo_we_o !== e_we) fail_line("R7", "we", fifo_we_o, e_we);
      else if (fifo_cs_o !== e_we) fail_line("R7", "cs", fifo_cs_o, e_we);
      else if (fifo_addr_o !== AW'(e_addr)) fail_line("R8", "addr", fifo_addr_o, e_addr);
      else if (fifo_data_o !== DW'(e_data)) fail_line("R7", "data", fifo_data_o, e_data);
      else if (frame_done_o !== e_done) fail_line("R9", "done", frame_done_o, e_done);
      else if (short_frame_o !== e_short) fail_line("R10", "short", short_frame_o, e_short);
      if (fifo_we_o) wr_cnt++;
      if (frame_done_o) done_cnt++;
    end
  end

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) fail_line(req, what, act, exp);
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  // one pixel slot: an enabled edge then a disabled one
  task automatic slot();
    half_en_i = 1'b1; tick();
    half_en_i = 1'b0; tick();
  endtask

  task automatic field_start(bit odd, bit en);
    field_odd_i = odd; capture_en_i = en;
    field_sync_i = 1'b1; slot();
    field_sync_i = 1'b0; slot();
  endtask

  task automatic do_line(int npix, int ls_at, int seed);
    line_sync_i = 1'b1; slot();
    line_sync_i = 1'b0; slot();
    for (int p = 0; p < npix; p++) begin
      line_valid_i = 1'b1; line_sync_i = (p == ls_at);
      pix_data_i = DW'(seed * 37 + p * 5);
      slot();
    end
    line_valid_i = 1'b0; line_sync_i = 1'b0;
    slot(); slot();
  endtask

  // line-valid only ever high at edges where the enable is low
  task automatic glitch_line(int npix);
    for (int p = 0; p < npix; p++) begin
      half_en_i = 1'b1; line_valid_i = 1'b0; tick();
      half_en_i = 1'b0; line_valid_i = 1'b1; pix_data_i = DW'(p); tick();
    end
    line_valid_i = 1'b0; slot(); slot();
  endtask

  task automatic lines(int n, int npix, int seed);
    for (int l = 0; l < n; l++) do_line(npix, -1, seed + l);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
      $finish;
    end
  end

  initial begin : main
    repeat (3) tick();
    // R1 reset values
    check_eq("R1", "we in reset", fifo_we_o, 0);
    check_eq("R1", "cs in reset", fifo_cs_o, 0);
    check_eq("R1", "addr in reset", fifo_addr_o, 0);
    check_eq("R1", "data in reset", fifo_data_o, 0);
    check_eq("R1", "done/short in reset", {frame_done_o, short_frame_o}, 0);
    rst_ni = 1'b1; slot();

    // R3 R4 R8 R9: full odd field, exact-size lines
    wr_cnt = 0; done_cnt = 0;
    field_start(1, 1); lines(12, 32, 1);
    check_eq("R8", "writes in full frame", wr_cnt, TOT);
    check_eq("R9", "done pulses", done_cnt, 1);

    // R5: even field ignored
    wr_cnt = 0;
    field_start(0, 1); lines(12, 32, 20);
    check_eq("R5", "writes in even field", wr_cnt, 0);

    // R6: enable low at field start, raised mid-field
    wr_cnt = 0;
    field_start(1, 0); capture_en_i = 1'b1; lines(12, 32, 40);
    check_eq("R6", "writes after late enable", wr_cnt, 0);

    // R6: enable dropped mid-field does not stop the frame
    wr_cnt = 0; done_cnt = 0;
    field_start(1, 1); capture_en_i = 1'b0; lines(12, 32, 60);
    check_eq("R6", "writes after early disable", wr_cnt, TOT);
    check_eq("R9", "done after early disable", done_cnt, 1);

    // R10: truncated field, then recovery
    wr_cnt = 0; done_cnt = 0;
    field_start(1, 1); lines(5, 32, 80);
    check_eq("R10", "short flag before next field", short_frame_o, 0);
    field_start(1, 1);
    check_eq("R10", "short flag after cut", short_frame_o, 1);
    lines(12, 32, 90);
    check_eq("R10", "short flag after full frame", short_frame_o, 0);
    check_eq("R10", "done count around cut", done_cnt, 1);

    // R3 R4: longer lines and extra lines are clipped
    wr_cnt = 0; done_cnt = 0;
    field_start(1, 1); lines(16, 40, 110);
    check_eq("R3", "writes with long lines", wr_cnt, TOT);
    check_eq("R4", "done with extra lines", done_cnt, 1);

    // R2: samples seen only on disabled edges
    wr_cnt = 0;
    field_start(1, 1); glitch_line(32);
    check_eq("R2", "writes from gated samples", wr_cnt, 0);
    lines(12, 32, 130);
    check_eq("R2", "writes after gated line", wr_cnt, TOT);

    // R11: line sync mid-line restarts numbering (3 + 6 kept in line 0)
    wr_cnt = 0; done_cnt = 0;
    field_start(1, 1); do_line(32, 10, 150);
    check_eq("R11", "writes in resynced line", wr_cnt, 9);
    lines(11, 32, 151);
    check_eq("R11", "frame still completes", done_cnt, 1);

    slot(); slot();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule